// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block sits beside a processor core and owns its two power-saving states. A power-save request carries a mode select. In the light mode (Idle) only the CPU clock is gated, and peripherals and the clock source keep running. In the deep mode (Sleep) the oscillator itself is stopped. The controller watches the interrupt sources, the watchdog time-out and the reset causes, and decides when to leave the low-power state. It records why the processor woke in three sticky status flags, which software clears with a strobe.

Leaving Idle takes one cycle. Leaving Sleep restarts the oscillator and waits out a start-up count of low-power clock ticks. If the oscillator is still not stable when the count runs out, the controller does one of two things. With clock monitoring enabled, it raises a clock-fail trap and selects the internal fallback oscillator. With monitoring disabled, it keeps waiting until the oscillator reports stable.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: In the Idle state `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1. `cpu_clk_en` is 1 only in the run state.
- R2: In the Sleep state `osc_en`, `periph_clk_en` and `cpu_clk_en` are all 0. `psave_mode`=1 selects Sleep and `psave_mode`=0 selects Idle.
- R3: Interrupt source i counts as a wake source only when `irq_req[i]` and `irq_en[i]` are both 1 and its priority field `irq_prio[i*PRIO_W +: PRIO_W]` is strictly greater than `cpu_prio`.
- R4: A wake condition seen in Idle returns the controller to run. `cpu_clk_en` and `stat_idle` are 1 one cycle later.
- R5: A wake condition seen in Sleep sets `stat_sleep` and `osc_en` one cycle later. `cpu_clk_en` returns only after OST_CYCLES pulses of `lp_tick` have been counted and `osc_stable` is 1.
- R6: A `wdt_timeout` wakes from either mode only while `wdt_en` is 1, and it then also sets `stat_wdto`. While `wdt_en` is 0 it has no effect.
- R7: `rst_por` forces run and clears `stat_sleep`, `stat_idle`, `stat_wdto` and `fallback_sel`.
- R8: `rst_other` forces run. It sets `stat_sleep` if it arrived in Sleep or during the oscillator wait, and it sets `stat_idle` if it arrived in Idle. `rst_por` takes precedence over `rst_other`.
- R9: If the start-up count has expired, `osc_stable` is 0 and `fscm_en` is 1, the controller returns to run with `clk_fail_trap` pulsed high for one cycle and `fallback_sel` set. `fallback_sel` stays set until a power-on reset.
- R10: If the start-up count has expired, `osc_stable` is 0 and `fscm_en` is 0, the controller keeps `cpu_clk_en` at 0 until `osc_stable` rises.
- R11: Status flags hold until `stat_clr` is pulsed. When a set and a clear happen in the same cycle, the set wins.
- R12: A `psave_req` in run is ignored while a wake condition (R3 or R6) is already present, and the controller stays in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| psave_req | input | 1 | Power-save request strobe |
| psave_mode | input | 1 | 1 = Sleep, 0 = Idle |
| irq_req | input | N_SRC | Interrupt requests |
| irq_en | input | N_SRC | Per-source enables |
| irq_prio | input | N_SRC*PRIO_W | Per-source priorities, source i at bits i*PRIO_W |
| cpu_prio | input | PRIO_W | Current CPU priority level |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out |
| rst_por | input | 1 | Power-on reset cause |
| rst_other | input | 1 | Any other reset cause |
| lp_tick | input | 1 | Low-power clock tick for start-up count |
| osc_stable | input | 1 | Oscillator reports stable |
| fscm_en | input | 1 | Fail-safe clock monitoring enable |
| stat_clr | input | 1 | Clear strobe for all status flags |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Primary oscillator enable |
| fallback_sel | output | 1 | Internal fallback oscillator selected |
| clk_fail_trap | output | 1 | One-cycle clock-fail trap request |
| stat_sleep | output | 1 | Woke from Sleep |
| stat_idle | output | 1 | Woke from Idle |
| stat_wdto | output | 1 | Watchdog time-out wake |

## Verification
Every output comes from a register that is updated on the edge where the deciding input is sampled. A stimulus applied before an edge therefore shows on the outputs one cycle later, and Sleep recovery adds the OST_CYCLES tick count on top of that. The bench drives its inputs on the falling edge. A behavioural model advances at the same rising edge as the design, and every output is compared at the following falling edge. This keeps each comparison exactly one edge after the stimulus that caused it. Directed sequences cover the wake paths, the clock-fail paths and the reset corners, and a random phase then mixes them.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_OSCW  = 2'd3
  } pstate_t;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int N_SRC  = 4,
  parameter int PRIO_W = 3
) (
  input  logic [N_SRC-1:0]        irq_req,
  input  logic [N_SRC-1:0]        irq_en,
  input  logic [N_SRC*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cpu_prio,
  output logic                    irq_wake
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = irq_req[i] & irq_en[i] &
                    (irq_prio[i*PRIO_W +: PRIO_W] > cpu_prio);
  end

  assign irq_wake = |hit;
endmodule

// File: rtl/pwr_ost_timer.sv
module pwr_ost_timer #(
  parameter int OST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(OST_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= LOADV;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pwr_status_bits.sv
module pwr_status_bits (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic clr,
  input  logic set_sleep,
  input  logic set_idle,
  input  logic set_wdto,
  output logic stat_sleep,
  output logic stat_idle,
  output logic stat_wdto
);
  always_ff @(posedge clk) begin
    if (rst || por) begin
      stat_sleep <= 1'b0;
      stat_idle  <= 1'b0;
      stat_wdto  <= 1'b0;
    end else begin
      stat_sleep <= set_sleep | (stat_sleep & ~clr);
      stat_idle  <= set_idle  | (stat_idle  & ~clr);
      stat_wdto  <= set_wdto  | (stat_wdto  & ~clr);
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_pkg::*;
#(
  parameter int N_SRC      = 4,
  parameter int PRIO_W     = 3,
  parameter int OST_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    psave_req,
  input  logic                    psave_mode,
  input  logic [N_SRC-1:0]        irq_req,
  input  logic [N_SRC-1:0]        irq_en,
  input  logic [N_SRC*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cpu_prio,
  input  logic                    wdt_en,
  input  logic                    wdt_timeout,
  input  logic                    rst_por,
  input  logic                    rst_other,
  input  logic                    lp_tick,
  input  logic                    osc_stable,
  input  logic                    fscm_en,
  input  logic                    stat_clr,
  output logic                    cpu_clk_en,
  output logic                    periph_clk_en,
  output logic                    osc_en,
  output logic                    fallback_sel,
  output logic                    clk_fail_trap,
  output logic                    stat_sleep,
  output logic                    stat_idle,
  output logic                    stat_wdto
);
  pstate_t st, st_n;
  logic irq_wake, wdt_wake, wake;
  logic ost_load, ost_done;
  logic set_sl, set_id, set_wd, trap_n, fb_set;

  pwr_wake_qual #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_qual (
    .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
    .cpu_prio(cpu_prio), .irq_wake(irq_wake)
  );

  assign wdt_wake = wdt_en & wdt_timeout;
  assign wake     = irq_wake | wdt_wake;

  pwr_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk(clk), .rst(rst), .load(ost_load), .tick(lp_tick), .done(ost_done)
  );

  always_comb begin
    st_n     = st;
    ost_load = 1'b0;
    set_sl   = 1'b0;
    set_id   = 1'b0;
    set_wd   = 1'b0;
    trap_n   = 1'b0;
    fb_set   = 1'b0;
    if (rst_por) begin
      st_n = ST_RUN;
    end else if (rst_other) begin
      st_n   = ST_RUN;
      set_sl = (st == ST_SLEEP) || (st == ST_OSCW);
      set_id = (st == ST_IDLE);
    end else begin
      unique case (st)
        ST_RUN: begin
          if (psave_req && !wake) st_n = psave_mode ? ST_SLEEP : ST_IDLE;
        end
        ST_IDLE: begin
          if (wake) begin
            st_n   = ST_RUN;
            set_id = 1'b1;
            set_wd = wdt_wake;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            st_n     = ST_OSCW;
            ost_load = 1'b1;
            set_sl   = 1'b1;
            set_wd   = wdt_wake;
          end
        end
        ST_OSCW: begin
          if (ost_done) begin
            if (osc_stable) begin
              st_n = ST_RUN;
            end else if (fscm_en) begin
              st_n   = ST_RUN;
              trap_n = 1'b1;
              fb_set = 1'b1;
            end
          end
        end
        default: st_n = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_RUN;
      clk_fail_trap <= 1'b0;
      fallback_sel  <= 1'b0;
    end else begin
      st            <= st_n;
      clk_fail_trap <= trap_n;
      if (rst_por)     fallback_sel <= 1'b0;
      else if (fb_set) fallback_sel <= 1'b1;
    end
  end

  assign cpu_clk_en    = (st == ST_RUN);
  assign periph_clk_en = (st == ST_RUN) || (st == ST_IDLE);
  assign osc_en        = (st != ST_SLEEP);

  pwr_status_bits u_stat (
    .clk(clk), .rst(rst), .por(rst_por), .clr(stat_clr),
    .set_sleep(set_sl), .set_idle(set_id), .set_wdto(set_wd),
    .stat_sleep(stat_sleep), .stat_idle(stat_idle), .stat_wdto(stat_wdto)
  );
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk
  import pwr_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    rst_por,
  input logic    rst_other,
  input pstate_t st,
  input logic    wake,
  input logic    fscm_en,
  input logic    osc_stable,
  input logic    cpu_clk_en,
  input logic    periph_clk_en,
  input logic    osc_en,
  input logic    clk_fail_trap,
  input logic    fallback_sel,
  input logic    stat_idle
);
  p_cpu_needs_clocks_r1: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (osc_en && periph_clk_en));

  p_sleep_all_off_r2: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!periph_clk_en && !cpu_clk_en));

  p_idle_wake_next_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && wake && !rst_por && !rst_other) |=> (cpu_clk_en && stat_idle));

  p_trap_with_fallback_r9: assert property (@(posedge clk) disable iff (rst)
    clk_fail_trap |-> (fallback_sel && cpu_clk_en));

  p_trap_single_r9: assert property (@(posedge clk) disable iff (rst)
    clk_fail_trap |=> !clk_fail_trap);

  p_hold_without_monitor_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OSCW && !fscm_en && !osc_stable && !rst_por && !rst_other) |=> !cpu_clk_en);
endmodule

bind pwr_wake_ctrl pwr_wake_chk u_chk (
  .clk(clk), .rst(rst), .rst_por(rst_por), .rst_other(rst_other),
  .st(st), .wake(wake), .fscm_en(fscm_en), .osc_stable(osc_stable),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
  .clk_fail_trap(clk_fail_trap), .fallback_sel(fallback_sel), .stat_idle(stat_idle)
);

// File: tb/sim_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_wake_ctrl;
  localparam int N  = 4;
  localparam int PW = 3;
  localparam int OST = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psave_req = 0, psave_mode = 0;
  logic [N-1:0] irq_req = '0, irq_en = '0;
  logic [N*PW-1:0] irq_prio = '0;
  logic [PW-1:0] cpu_prio = '0;
  logic wdt_en = 0, wdt_timeout = 0, rst_por = 0, rst_other = 0;
  logic lp_tick = 0, osc_stable = 0, fscm_en = 0, stat_clr = 0;
  logic cpu_clk_en, periph_clk_en, osc_en, fallback_sel, clk_fail_trap;
  logic stat_sleep, stat_idle, stat_wdto;

  always #2.5 clk = ~clk;

  pwr_wake_ctrl #(.N_SRC(N), .PRIO_W(PW), .OST_CYCLES(OST)) u0 (
    .clk(clk), .rst(rst), .psave_req(psave_req), .psave_mode(psave_mode),
    .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .rst_por(rst_por),
    .rst_other(rst_other), .lp_tick(lp_tick), .osc_stable(osc_stable),
    .fscm_en(fscm_en), .stat_clr(stat_clr), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .fallback_sel(fallback_sel),
    .clk_fail_trap(clk_fail_trap), .stat_sleep(stat_sleep), .stat_idle(stat_idle),
    .stat_wdto(stat_wdto)
  );

  // behavioural model: mode 0 run, 1 idle, 2 sleep, 3 oscillator wait
  int m_mode = 0, m_cnt = 0;
  bit m_sl, m_id, m_wd, m_fb, m_trap;
  int vectors = 0, miscompares = 0;

  function automatic bit pending_wake();
    bit w = 0;
    for (int i = 0; i < N; i++)
      if (irq_req[i] && irq_en[i] && (int'(irq_prio[i*PW +: PW]) > int'(cpu_prio))) w = 1;
    if (wdt_en && wdt_timeout) w = 1;
    return w;
  endfunction

  always @(posedge clk) begin
    bit w, wd, ssl, sid, swd, ld;
    int nm;
    w = pending_wake(); wd = wdt_en && wdt_timeout;
    ssl = 0; sid = 0; swd = 0; ld = 0; nm = m_mode;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_sl = 0; m_id = 0; m_wd = 0; m_fb = 0; m_trap = 0;
    end else if (rst_por) begin
      m_mode = 0; m_sl = 0; m_id = 0; m_wd = 0; m_fb = 0; m_trap = 0;
      if (lp_tick && m_cnt > 0) m_cnt--;
    end else begin
      m_trap = 0;
      if (rst_other) begin
        nm = 0; ssl = (m_mode >= 2); sid = (m_mode == 1);
      end else if (m_mode == 0) begin
        if (psave_req && !w) nm = psave_mode ? 2 : 1;
      end else if (m_mode == 1) begin
        if (w) begin nm = 0; sid = 1; swd = wd; end
      end else if (m_mode == 2) begin
        if (w) begin nm = 3; ssl = 1; swd = wd; ld = 1; end
      end else begin
        if (m_cnt == 0) begin
          if (osc_stable) nm = 0;
          else if (fscm_en) begin nm = 0; m_trap = 1; m_fb = 1; end
        end
      end
      m_sl = ssl || (m_sl && !stat_clr);
      m_id = sid || (m_id && !stat_clr);
      m_wd = swd || (m_wd && !stat_clr);
      m_mode = nm;
      if (ld) m_cnt = OST;
      else if (lp_tick && m_cnt > 0) m_cnt--;
    end
  end

  task automatic cmp1(input string nm, input string req, input logic act, input bit exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp1("cpu_clk_en",    "R1", cpu_clk_en,    m_mode == 0);
    cmp1("periph_clk_en", "R2", periph_clk_en, m_mode <= 1);
    cmp1("osc_en",        "R5", osc_en,        m_mode != 2);
    cmp1("fallback_sel",  "R9", fallback_sel,  m_fb);
    cmp1("clk_fail_trap", "R9", clk_fail_trap, m_trap);
    cmp1("stat_sleep",    "R11", stat_sleep,   m_sl);
    cmp1("stat_idle",     "R11", stat_idle,    m_id);
    cmp1("stat_wdto",     "R6", stat_wdto,     m_wd);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic clear_pulses();
    psave_req = 0; rst_por = 0; rst_other = 0; stat_clr = 0; wdt_timeout = 0;
  endtask

  task automatic enter(input bit sleep);
    psave_req = 1; psave_mode = sleep; cyc(); clear_pulses();
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      miscompares++; vectors++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); rst = 0; cyc();              // reset state
    irq_prio = {3'd1, 3'd5, 3'd3, 3'd4}; cpu_prio = 3'd3;
    // R1 R3 R4: idle; low priority and disabled sources must not wake
    enter(0); idle_n(2);
    irq_en = 4'b0010; irq_req = 4'b0001; idle_n(2);   // R3 disabled source
    irq_en = 4'b0010; irq_req = 4'b0010; cyc();       // R3 prio 3 not above 3
    irq_en = 4'b0100; irq_req = 4'b0100; cyc();       // R4 prio 5 wakes
    irq_req = 0; idle_n(2);
    // R11 clear, and set beats clear in same cycle
    stat_clr = 1; cyc(); stat_clr = 0; cyc();
    enter(0); irq_req = 4'b0100; stat_clr = 1; cyc(); irq_req = 0; stat_clr = 0; idle_n(2);
    // R2 R5 sleep wake with start-up count
    enter(1); idle_n(3);
    irq_req = 4'b0100; cyc(); irq_req = 0;
    osc_stable = 1; lp_tick = 1; idle_n(OST + 3); lp_tick = 0;
    // R6 watchdog disabled ignored, then enabled
    enter(1); wdt_timeout = 1; cyc(); wdt_timeout = 0; idle_n(2);
    wdt_en = 1; wdt_timeout = 1; cyc(); wdt_timeout = 0; lp_tick = 1; idle_n(OST + 3);
    wdt_en = 0; lp_tick = 0; stat_clr = 1; cyc(); stat_clr = 0;
    // R9 clock fail with monitoring
    osc_stable = 0; fscm_en = 1;
    enter(1); irq_req = 4'b0100; cyc(); irq_req = 0; lp_tick = 1; idle_n(OST + 4); lp_tick = 0;
    // R10 no monitoring: wait for oscillator
    fscm_en = 0;
    enter(1); irq_req = 4'b0100; cyc(); irq_req = 0; lp_tick = 1; idle_n(OST + 10);
    osc_stable = 1; idle_n(3); lp_tick = 0;
    // R12 power-save ignored with wake pending
    irq_req = 4'b0100; enter(1); idle_n(2); irq_req = 0;
    // R8 other reset from idle and from sleep
    enter(0); rst_other = 1; cyc(); clear_pulses(); idle_n(2);
    enter(1); rst_other = 1; cyc(); clear_pulses(); idle_n(2);
    // R7 power-on reset clears flags and fallback, beats rst_other
    enter(0); rst_por = 1; rst_other = 1; cyc(); clear_pulses(); idle_n(2);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      psave_req   = ($urandom_range(0, 7) == 0);
      psave_mode  = $urandom_range(0, 1);
      irq_req     = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
      irq_en      = 4'($urandom);
      cpu_prio    = 3'($urandom);
      wdt_en      = $urandom_range(0, 1);
      wdt_timeout = ($urandom_range(0, 30) == 0);
      rst_por     = ($urandom_range(0, 300) == 0);
      rst_other   = ($urandom_range(0, 200) == 0);
      lp_tick     = $urandom_range(0, 1);
      osc_stable  = ($urandom_range(0, 3) != 0);
      fscm_en     = $urandom_range(0, 1);
      stat_clr    = ($urandom_range(0, 15) == 0);
      cyc();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule